// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block chooses the one pending interrupt that should be offered to a single processor. A bank of local request lines comes in as three inputs: an eligibility bit per line, an 8-bit priority per line and a small group code per line. A separate candidate also arrives from an external message-interrupt tracker, with its own ID, priority and group. After a `start` pulse the block steps through the local lines at one line per clock and keeps a running best entry (ID, priority, group). It then spends one more clock weighing the message candidate against that entry. It finishes with a one-cycle `done` strobe. At that point `valid` shows whether anything is pending.

A smaller priority value is more urgent. When two priorities are equal, the lower or equal ID wins. The priority value 0xFF is reserved and means "nothing pending". A scan started with `clear_best` is a full rescan from 0xFF. A scan started without it is incremental and begins from the stored best. If an incremental pass finds nothing at least as good, and the stored best lies in the local range or the message range, the stored entry may no longer be correct. The block then clears it and runs a full pass at once. Whoever drives the block holds the inputs stable from `start` until `done`.

Top module: `hppi_picker`

## Requirements
- R1: A candidate with a numerically lower priority than the running best replaces it. After the scan, the result carries the lowest priority among the considered candidates.
- R2: Among candidates with equal priority, the one with the lower or equal ID wins. If the top priority is shared by several local lines, the lowest line number is reported.
- R3: After reset, `best_prio` is 0xFF, `valid` is 0, `done` is 0, `best_id` is 0 and `best_grp` is 0.
- R4: `valid` is 1 exactly when `best_prio` differs from 0xFF.
- R5: A local line whose `elig` bit is 0 is never chosen, whatever its priority.
- R6: The message candidate is considered only when `msg_en_cpu`, `msg_en_glob` and `grp1ns_en` are all 1 and `msg_prio` is not 0xFF. When it wins, `best_id`, `best_prio` and `best_grp` take `msg_id`, `msg_prio` and `msg_grp`.
- R7: A `start` with `clear_best`=1 forces the best priority to 0xFF and scans everything. `done` is high in the 33rd cycle after the clock edge that sampled `start`.
- R8: A `start` with `clear_best`=0 begins from the stored best, and re-finding that same entry counts as a win (latency 33). If no candidate is at least as good as the stored valid best, and its ID is below 32 or at least `MSG_BASE` (default 8192), a full pass follows and `done` comes in cycle 66.
- R9: `best_grp` changes only when a new winner is taken. A pass that takes no winner leaves `best_id` and `best_grp` as they were.
- R10: `start` is ignored while a scan is running, and `done` is high for exactly one cycle.
- R11: If an incremental pass finds nothing and the stored best ID lies between 32 and `MSG_BASE`-1, that best is kept without a second pass (latency 33).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a selection pass (sampled in idle only) |
| clear_best | input | 1 | With start: full rescan from priority 0xFF |
| elig | input | NUM_LOCAL | Per-line eligibility |
| prio_flat | input | NUM_LOCAL*PRIO_W | Per-line priority, line k at bits [k*PRIO_W +: PRIO_W] |
| grp_flat | input | NUM_LOCAL*GRP_W | Per-line group, line k at bits [k*GRP_W +: GRP_W] |
| msg_id | input | ID_W | Message candidate ID |
| msg_prio | input | PRIO_W | Message candidate priority |
| msg_grp | input | GRP_W | Message candidate group |
| msg_en_cpu | input | 1 | Per-processor message enable |
| msg_en_glob | input | 1 | Global message enable |
| grp1ns_en | input | 1 | Non-secure Group 1 enable |
| done | output | 1 | One-cycle completion strobe |
| valid | output | 1 | Something is pending |
| best_id | output | ID_W | Winning ID |
| best_prio | output | PRIO_W | Winning priority |
| best_grp | output | GRP_W | Winning group |

## Verification
Two outcomes can be settled in the same final comparison cycle. The message candidate can take the best entry, or, when it does not, the fallback decision can reset the pass. Incremental runs are set up so that the previous winner drops out and the message gate is open or closed, and the bench predicts from its own model whether the result arrives at latency 33 or 66. A second pair also meets in one cycle: a `start` pulse given in the middle of a scan, and the running scan. It is judged by checking that the result and the latency match an undisturbed run.

// File: rtl/hppi_pkg.sv
package hppi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_MSG  = 2'd2
    } hp_state_e;
endpackage

// File: rtl/hppi_lane_pick.sv
module hppi_lane_pick #(
    parameter int NUM_LOCAL = 32,
    parameter int PRIO_W    = 8,
    parameter int GRP_W     = 2,
    localparam int IDX_W    = $clog2(NUM_LOCAL)
) (
    input  logic [NUM_LOCAL-1:0]        elig,
    input  logic [NUM_LOCAL*PRIO_W-1:0] prio_flat,
    input  logic [NUM_LOCAL*GRP_W-1:0]  grp_flat,
    input  logic [IDX_W-1:0]            idx,
    output logic                        lane_elig,
    output logic [PRIO_W-1:0]           lane_prio,
    output logic [GRP_W-1:0]            lane_grp
);
    logic [PRIO_W-1:0] prio_arr [NUM_LOCAL];
    logic [GRP_W-1:0]  grp_arr  [NUM_LOCAL];

    for (genvar k = 0; k < NUM_LOCAL; k++) begin : g_unpack
        assign prio_arr[k] = prio_flat[k*PRIO_W +: PRIO_W];
        assign grp_arr[k]  = grp_flat[k*GRP_W +: GRP_W];
    end

    assign lane_elig = elig[idx];
    assign lane_prio = prio_arr[idx];
    assign lane_grp  = grp_arr[idx];
endmodule

// File: rtl/hppi_cmp.sv
module hppi_cmp #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 16
) (
    input  logic              cand_ok,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [ID_W-1:0]   best_id,
    input  logic [PRIO_W-1:0] best_prio,
    output logic              win
);
    // Lower value is more urgent; equal priority goes to lower-or-equal ID.
    always_comb begin
        win = 1'b0;
        if (cand_ok) begin
            if (cand_prio < best_prio)
                win = 1'b1;
            else if (cand_prio == best_prio && cand_id <= best_id)
                win = 1'b1;
        end
    end
endmodule

// File: rtl/hppi_picker.sv
module hppi_picker #(
    parameter int NUM_LOCAL = 32,
    parameter int PRIO_W    = 8,
    parameter int ID_W      = 16,
    parameter int GRP_W     = 2,
    parameter int MSG_BASE  = 8192
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        clear_best,
    input  logic [NUM_LOCAL-1:0]        elig,
    input  logic [NUM_LOCAL*PRIO_W-1:0] prio_flat,
    input  logic [NUM_LOCAL*GRP_W-1:0]  grp_flat,
    input  logic [ID_W-1:0]             msg_id,
    input  logic [PRIO_W-1:0]           msg_prio,
    input  logic [GRP_W-1:0]            msg_grp,
    input  logic                        msg_en_cpu,
    input  logic                        msg_en_glob,
    input  logic                        grp1ns_en,
    output logic                        done,
    output logic                        valid,
    output logic [ID_W-1:0]             best_id,
    output logic [PRIO_W-1:0]           best_prio,
    output logic [GRP_W-1:0]            best_grp
);
    import hppi_pkg::*;

    localparam int                IDX_W     = $clog2(NUM_LOCAL);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_LOCAL - 1);
    localparam logic [PRIO_W-1:0] NONE_PRIO = {PRIO_W{1'b1}};
    localparam logic [ID_W-1:0]   LOCAL_TOP = ID_W'(NUM_LOCAL);
    localparam logic [ID_W-1:0]   MSG_LOW   = ID_W'(MSG_BASE);

    typedef struct packed {
        hp_state_e          state;
        logic [IDX_W-1:0]   idx;
        logic [ID_W-1:0]    id;
        logic [PRIO_W-1:0]  prio;
        logic [GRP_W-1:0]   grp;
        logic               seen;
        logic               full;
        logic               done;
    } pick_regs_t;

    pick_regs_t r_d, r_q;

    logic              lane_elig;
    logic [PRIO_W-1:0] lane_prio;
    logic [GRP_W-1:0]  lane_grp;
    logic              lane_win;
    logic              msg_ok;
    logic              msg_win;
    logic              seen_after;
    logic              need_full;

    hppi_lane_pick #(
        .NUM_LOCAL (NUM_LOCAL),
        .PRIO_W    (PRIO_W),
        .GRP_W     (GRP_W)
    ) u_lane (
        .elig      (elig),
        .prio_flat (prio_flat),
        .grp_flat  (grp_flat),
        .idx       (r_q.idx),
        .lane_elig (lane_elig),
        .lane_prio (lane_prio),
        .lane_grp  (lane_grp)
    );

    hppi_cmp #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_cmp_lane (
        .cand_ok   (lane_elig),
        .cand_id   (ID_W'(r_q.idx)),
        .cand_prio (lane_prio),
        .best_id   (r_q.id),
        .best_prio (r_q.prio),
        .win       (lane_win)
    );

    assign msg_ok = msg_en_cpu && msg_en_glob && grp1ns_en && (msg_prio != NONE_PRIO);

    hppi_cmp #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_cmp_msg (
        .cand_ok   (msg_ok),
        .cand_id   (msg_id),
        .cand_prio (msg_prio),
        .best_id   (r_q.id),
        .best_prio (r_q.prio),
        .win       (msg_win)
    );

    // Fallback: nothing at least as good, old best still valid and in a scanned range.
    assign seen_after = r_q.seen || msg_win;
    assign need_full  = !seen_after && !r_q.full && (r_q.prio != NONE_PRIO) &&
                        ((r_q.id < LOCAL_TOP) || (r_q.id >= MSG_LOW));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_SCAN;
                    r_d.idx   = '0;
                    r_d.seen  = 1'b0;
                    r_d.full  = clear_best;
                    if (clear_best)
                        r_d.prio = NONE_PRIO;
                end
            end
            ST_SCAN: begin
                if (lane_win) begin
                    r_d.id   = ID_W'(r_q.idx);
                    r_d.prio = lane_prio;
                    r_d.grp  = lane_grp;
                    r_d.seen = 1'b1;
                end
                if (r_q.idx == LAST_IDX)
                    r_d.state = ST_MSG;
                else
                    r_d.idx = r_q.idx + 1'b1;
            end
            ST_MSG: begin
                if (msg_win) begin
                    r_d.id   = msg_id;
                    r_d.prio = msg_prio;
                    r_d.grp  = msg_grp;
                    r_d.seen = 1'b1;
                end
                if (need_full) begin
                    r_d.prio  = NONE_PRIO;
                    r_d.full  = 1'b1;
                    r_d.seen  = 1'b0;
                    r_d.idx   = '0;
                    r_d.state = ST_SCAN;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.idx   <= '0;
            r_q.id    <= '0;
            r_q.prio  <= NONE_PRIO;
            r_q.grp   <= '0;
            r_q.seen  <= 1'b0;
            r_q.full  <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = r_q.done;
    assign best_id   = r_q.id;
    assign best_prio = r_q.prio;
    assign best_grp  = r_q.grp;
    assign valid     = (r_q.prio != NONE_PRIO);

    // R1: while stepping lines the running best priority never gets less urgent
    assert_scan_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SCAN) |=> (best_prio <= $past(best_prio)));

    // R5: an ineligible line never becomes the best ID
    assert_inelig_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SCAN && !lane_elig) |=> $stable(best_id));

    // R6: with any of the three message enables off, the message step leaves the ID alone
    assert_msg_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_MSG && !(msg_en_cpu && msg_en_glob && grp1ns_en)) |=> $stable(best_id));

    // R9: idle without start keeps the result
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && !start) |=>
            ($stable(best_id) && $stable(best_prio) && $stable(best_grp)));

    // R10: completion strobe lasts one cycle
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/hppi_picker_test.sv
module hppi_picker_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;
    localparam int MSGB       = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic clear_best = 1'b0;
    logic [N-1:0]   elig;
    logic [N*8-1:0] prio_flat;
    logic [N*2-1:0] grp_flat;
    logic [15:0] msg_id = '0;
    logic [7:0]  msg_prio = 8'hFF;
    logic [1:0]  msg_grp = '0;
    logic msg_en_cpu = 1'b0, msg_en_glob = 1'b0, grp1ns_en = 1'b0;
    logic done, valid;
    logic [15:0] best_id;
    logic [7:0]  best_prio;
    logic [1:0]  best_grp;

    logic       el [N];
    logic [7:0] lp [N];
    logic [1:0] lg [N];

    for (genvar k = 0; k < N; k++) begin : g_drive
        assign elig[k]            = el[k];
        assign prio_flat[k*8 +: 8] = lp[k];
        assign grp_flat[k*2 +: 2]  = lg[k];
    end

    hppi_picker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear_best(clear_best),
        .elig(elig), .prio_flat(prio_flat), .grp_flat(grp_flat),
        .msg_id(msg_id), .msg_prio(msg_prio), .msg_grp(msg_grp),
        .msg_en_cpu(msg_en_cpu), .msg_en_glob(msg_en_glob), .grp1ns_en(grp1ns_en),
        .done(done), .valid(valid), .best_id(best_id), .best_prio(best_prio),
        .best_grp(best_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    id, prio, grp, vld, lat, st;
        string tag;
    } exp_t;
    exp_t q[$];

    // model state
    logic [15:0] m_id = '0;
    logic [7:0]  m_prio = 8'hFF;
    logic [1:0]  m_grp = '0;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit better(logic [15:0] cid, logic [7:0] cp,
                                  logic [15:0] bid, logic [7:0] bp);
        return (cp < bp) || (cp == bp && cid <= bid);
    endfunction

    function automatic void pass(inout logic [15:0] bid, inout logic [7:0] bp,
                                 inout logic [1:0] bg, inout bit seen);
        for (int k = 0; k < N; k++)
            if (el[k] && better(16'(k), lp[k], bid, bp)) begin
                bid = 16'(k); bp = lp[k]; bg = lg[k]; seen = 1'b1;
            end
        if (msg_en_cpu && msg_en_glob && grp1ns_en && msg_prio != 8'hFF &&
            better(msg_id, msg_prio, bid, bp)) begin
            bid = msg_id; bp = msg_prio; bg = msg_grp; seen = 1'b1;
        end
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check("R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "best_id",   int'(best_id),   e.id);
                check(e.tag, "best_prio", int'(best_prio), e.prio);
                check(e.tag, "best_grp",  int'(best_grp),  e.grp);
                check(e.tag, "valid(R4)", int'(valid),     e.vld);
                check(e.tag, "latency",   cyc - e.st,      e.lat);
            end
        end
    end

    task automatic run(bit clr, bit poke, string tag);
        exp_t e;
        bit seen = 1'b0;
        int lat = 33;
        if (clr) m_prio = 8'hFF;
        pass(m_id, m_prio, m_grp, seen);
        if (!seen && !clr && m_prio != 8'hFF && (m_id < N || m_id >= MSGB)) begin
            m_prio = 8'hFF;
            pass(m_id, m_prio, m_grp, seen);
            lat = 66;
        end
        e.id = int'(m_id); e.prio = int'(m_prio); e.grp = int'(m_grp);
        e.vld = (m_prio != 8'hFF) ? 1 : 0; e.lat = lat; e.tag = tag;
        @(negedge clk);
        start = 1'b1; clear_best = clr;
        @(posedge clk); #1;
        e.st = cyc;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0; clear_best = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1; clear_best = 1'b1;
            @(negedge clk);
            start = 1'b0; clear_best = 1'b0;
        end
        while (q.size() != 0) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        check("R10", "done low after strobe", int'(done), 0);
    endtask

    task automatic clear_lines();
        for (int k = 0; k < N; k++) begin
            el[k] = 1'b0; lp[k] = 8'hA0; lg[k] = 2'(k);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        clear_lines();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3, R4: reset state
        check("R3", "reset best_prio", int'(best_prio), 255);
        check("R3", "reset valid",     int'(valid),     0);
        check("R3", "reset done",      int'(done),      0);
        check("R3", "reset best_id",   int'(best_id),   0);
        check("R3", "reset best_grp",  int'(best_grp),  0);

        // R1, R2, R7: full scan with a tie on the top priority
        el[5] = 1; lp[5] = 8'h40;
        el[9] = 1; lp[9] = 8'h20; lg[9] = 2'd3;
        el[20] = 1; lp[20] = 8'h20;
        run(1'b1, 1'b0, "R1/R2/R7");

        // R5: very urgent but ineligible line
        lp[3] = 8'h01;
        run(1'b1, 1'b0, "R5");

        // R8: incremental re-check finds the same best
        run(1'b0, 1'b0, "R8 recheck");

        // R8: old best drops out, fallback to full pass
        el[9] = 0;
        run(1'b0, 1'b0, "R8 fallback");

        // R6: message wins with all enables
        msg_id = 16'd8200; msg_prio = 8'h10; msg_grp = 2'd2;
        msg_en_cpu = 1; msg_en_glob = 1; grp1ns_en = 1;
        run(1'b1, 1'b0, "R6 msg wins");
        // R8 fallback decided in the message cycle: msg gate closed, msg was best
        msg_en_glob = 0;
        run(1'b0, 1'b0, "R6/R8 msg drop");
        msg_en_glob = 1; msg_en_cpu = 0;
        run(1'b1, 1'b0, "R6 cpu off");
        msg_en_cpu = 1; grp1ns_en = 0;
        run(1'b1, 1'b0, "R6 grp1ns off");
        grp1ns_en = 1; msg_prio = 8'hFF;
        run(1'b1, 1'b0, "R6 msg prio none");

        // R11: best ID in the middle range survives an empty incremental pass
        msg_id = 16'd100; msg_prio = 8'h05; msg_grp = 2'd1;
        run(1'b1, 1'b0, "R6 mid id");
        msg_en_cpu = 0;
        run(1'b0, 1'b0, "R11");

        // R9, R4: nothing eligible keeps id and group, valid drops
        clear_lines();
        run(1'b1, 1'b0, "R9/R4 empty");

        // R2: all lines tied
        for (int k = 0; k < N; k++) begin el[k] = 1; lp[k] = 8'h80; end
        lp[31] = 8'h80; lg[0] = 2'd2;
        run(1'b1, 1'b0, "R2 all tied");

        // R10: start pulse in the middle of a scan is ignored
        el[0] = 0; lp[17] = 8'h30;
        run(1'b0, 1'b1, "R10 busy start");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule